// File: doc/BRIEF.md
# Dual-Index Compressed Line Cache Controller

This block manages the tag and occupancy state of a direct-mapped cache whose every set is a 64-byte slot. The slot holds either one uncompressed line or two compressed lines, each with its own tag. Every line address has two legal home sets. One is the conventional set, taken from the low index bits. The other is a bandwidth-aware set, which moves address bit `INDEX_W` into the lowest index position so that an even line and the odd line after it land together. The two candidate sets differ only in index bit 0, so they are neighbours and one probe examines both.

A read looks for the address in both candidates. On a hit it reports the set and how many lines that set returns. A fill first tries the bandwidth-aware set, which it can use only when the line is compressed and that slot has room. Failing that it tries the conventional set. If the conventional set is also full, the controller empties it and reports each dirty line on the writeback port before it stores the new line. The line data itself, compression and the backing memory all lie outside the block: the block tracks only addresses, sizes and state bits.

Top module: `dual_index_ccache`

## Requirements
- R1: After reset, no set holds a valid line, `reqReady` is 1, and both `respValid` and `wbValid` are 0.
- R2: For line address `a`, the conventional set is `a[INDEX_W-1:0]` and the bandwidth-aware set is `{a[INDEX_W-1:1], a[INDEX_W]}`. Lines 2k and 2k+1 therefore share a bandwidth-aware set even when their conventional sets differ.
- R3: A read compares `reqAddr` with every valid tag in both candidate sets. On a hit, `respHit`=1, `respSet` is the set holding the line, and `respCount` is the number of valid lines in that set (1 or 2). On a miss, `respHit`=0, `respSet` is the conventional set and `respCount`=0.
- R4: A fill with `reqSize` of 32 or less counts as compressed. It goes to the bandwidth-aware set when that set has a free way and the occupied bytes plus `reqSize` do not exceed 64.
- R5: Any other fill goes to the conventional set, provided that set has a free way and room for the line. A line with `reqSize` greater than 32 occupies the full 64 bytes, so it fits only in an empty slot.
- R6: When the conventional set lacks room, every line in it is removed. Each dirty line is reported on `wbValid`/`wbAddr` for exactly one cycle, way 0 before way 1. Clean lines are dropped without a writeback. The new line then becomes the only line in that set.
- R7: A fill whose address is already present keeps the line where it is, sets its dirty bit if `reqDirty`=1, and responds with `respHit`=1 and the set that holds it.
- R8: `reqReady` is 1 only while the controller is idle. Each accepted request yields exactly one single-cycle `respValid` pulse, and any writebacks come before that pulse.
- R9: The response to a fill reports in `respSet` the set that holds the line, and in `respCount` the number of valid lines in that set after placement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle and able to accept |
| reqWrite | input | 1 | 1 = fill, 0 = read |
| reqAddr | input | ADDR_W | Line address |
| reqSize | input | 7 | Compressed size of a fill in bytes (1..64) |
| reqDirty | input | 1 | Fill carries modified data |
| respValid | output | 1 | Response pulse |
| respHit | output | 1 | Line found in a candidate set |
| respSet | output | INDEX_W | Set reported by the response |
| respCount | output | 2 | Lines held in the reported set |
| wbValid | output | 1 | Dirty line being evicted |
| wbAddr | output | ADDR_W | Address of the evicted line |

## Verification
The hardest case to reach from the ports is an eviction of two dirty compressed lines. It needs a set that is full under both of its indices at the same moment, so that a new compressed line has nowhere else to go. The bench fills two dirty neighbour lines whose conventional and bandwidth-aware sets coincide. It then fills a third compressed line that maps to that same set under both indices, and checks that two writebacks come out in way order before the response. A second sequence dirties a clean line through a fill hit and then forces it out with an incompressible line. This shows that a dirty bit set by a later fill is honoured and that clean lines stay silent.

// File: rtl/dixc_pkg.sv
package dixc_pkg;
  localparam int SIZE_W     = 7;
  localparam int SLOT_BYTES = 64;
  localparam int HALF_BYTES = 32;

  typedef struct packed {
    logic latchReq;
    logic recordLookup;
    logic markDirty;
    logic placeBai;
    logic placeTsi;
    logic clearTsi;
    logic wbEmit;
    logic wbWay;
    logic respOut;
  } ctrlStrb_t;

  typedef struct packed {
    logic isWrite;
    logic hit;
    logic baiFits;
    logic tsiFits;
  } dpStat_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROBE,
    ST_EVICT,
    ST_PLACE,
    ST_RESP
  } ctrlState_t;
endpackage

// File: rtl/dixc_datapath.sv
module dixc_datapath
  import dixc_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int INDEX_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrb_t           strb,
  output dpStat_t             stat,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [SIZE_W-1:0]   reqSize,
  input  logic                reqDirty,
  input  logic                reqWrite,
  output logic                respHit,
  output logic [INDEX_W-1:0]  respSet,
  output logic [1:0]          respCount,
  output logic                wbValid,
  output logic [ADDR_W-1:0]   wbAddr
);
  localparam int NSETS = 1 << INDEX_W;
  localparam int WAYS  = 2;

  logic              lineV [NSETS][WAYS];
  logic              lineD [NSETS][WAYS];
  logic [SIZE_W-1:0] lineS [NSETS][WAYS];
  logic [ADDR_W-1:0] lineT [NSETS][WAYS];

  logic [ADDR_W-1:0]  addrQ;
  logic [SIZE_W-1:0]  sizeQ;
  logic               dirtyQ;
  logic               writeQ;
  logic [INDEX_W-1:0] setQ;
  logic               hitQ;

  logic [INDEX_W-1:0] tsiIdx, baiIdx, hitSet;
  logic [INDEX_W-1:0] candIdx [2];
  logic               match [2][WAYS];
  logic [7:0]         usedBytes [2];
  logic               freeWay [2];
  logic               placeWay [2];
  logic               compressible, hitWay, hitAny;
  logic [SIZE_W-1:0]  effSize;

  assign tsiIdx       = addrQ[INDEX_W-1:0];
  assign baiIdx       = {addrQ[INDEX_W-1:1], addrQ[INDEX_W]};
  assign compressible = (sizeQ <= SIZE_W'(HALF_BYTES));
  assign effSize      = compressible ? sizeQ : SIZE_W'(SLOT_BYTES);
  assign candIdx[0]   = tsiIdx;
  assign candIdx[1]   = baiIdx;

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      usedBytes[c] = 8'd0;
      for (int w = 0; w < WAYS; w++) begin
        match[c][w] = lineV[candIdx[c]][w] && (lineT[candIdx[c]][w] == addrQ);
        if (lineV[candIdx[c]][w])
          usedBytes[c] = usedBytes[c] + {1'b0, lineS[candIdx[c]][w]};
      end
      freeWay[c]  = !lineV[candIdx[c]][0] || !lineV[candIdx[c]][1];
      placeWay[c] = lineV[candIdx[c]][0];
    end
  end

  always_comb begin
    hitAny = 1'b0;
    hitSet = tsiIdx;
    hitWay = 1'b0;
    for (int c = 1; c >= 0; c--) begin
      for (int w = WAYS - 1; w >= 0; w--) begin
        if (match[c][w]) begin
          hitAny = 1'b1;
          hitSet = candIdx[c];
          hitWay = w[0];
        end
      end
    end
  end

  assign stat.isWrite = writeQ;
  assign stat.hit     = hitAny;
  assign stat.baiFits = compressible && freeWay[1] &&
                        (usedBytes[1] + {1'b0, effSize} <= 8'(SLOT_BYTES));
  assign stat.tsiFits = freeWay[0] &&
                        (usedBytes[0] + {1'b0, effSize} <= 8'(SLOT_BYTES));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NSETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          lineV[s][w] <= 1'b0;
          lineD[s][w] <= 1'b0;
          lineS[s][w] <= '0;
          lineT[s][w] <= '0;
        end
      end
      addrQ  <= '0;
      sizeQ  <= '0;
      dirtyQ <= 1'b0;
      writeQ <= 1'b0;
      setQ   <= '0;
      hitQ   <= 1'b0;
    end else begin
      if (strb.latchReq) begin
        addrQ  <= reqAddr;
        sizeQ  <= reqSize;
        dirtyQ <= reqDirty;
        writeQ <= reqWrite;
      end
      if (strb.recordLookup) begin
        setQ <= hitAny ? hitSet : tsiIdx;
        hitQ <= hitAny;
      end
      if (strb.markDirty && dirtyQ)
        lineD[hitSet][hitWay] <= 1'b1;
      if (strb.placeBai) begin
        setQ <= baiIdx;
        lineV[baiIdx][placeWay[1]] <= 1'b1;
        lineD[baiIdx][placeWay[1]] <= dirtyQ;
        lineS[baiIdx][placeWay[1]] <= effSize;
        lineT[baiIdx][placeWay[1]] <= addrQ;
      end
      if (strb.clearTsi) begin
        for (int w = 0; w < WAYS; w++) begin
          lineV[tsiIdx][w] <= 1'b0;
          lineD[tsiIdx][w] <= 1'b0;
        end
      end
      if (strb.placeTsi) begin
        setQ <= tsiIdx;
        lineV[tsiIdx][strb.clearTsi ? 1'b0 : placeWay[0]] <= 1'b1;
        lineD[tsiIdx][strb.clearTsi ? 1'b0 : placeWay[0]] <= dirtyQ;
        lineS[tsiIdx][strb.clearTsi ? 1'b0 : placeWay[0]] <= effSize;
        lineT[tsiIdx][strb.clearTsi ? 1'b0 : placeWay[0]] <= addrQ;
      end
    end
  end

  logic [1:0] setLines;
  assign setLines  = {1'b0, lineV[setQ][0]} + {1'b0, lineV[setQ][1]};
  assign respHit   = strb.respOut && hitQ;
  assign respSet   = strb.respOut ? setQ : '0;
  assign respCount = (strb.respOut && (hitQ || writeQ)) ? setLines : 2'd0;

  assign wbValid = strb.wbEmit && lineV[tsiIdx][strb.wbWay] && lineD[tsiIdx][strb.wbWay];
  assign wbAddr  = wbValid ? lineT[tsiIdx][strb.wbWay] : '0;
endmodule

// File: rtl/dixc_ctrl.sv
module dixc_ctrl
  import dixc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  output logic      reqReady,
  input  dpStat_t   stat,
  output ctrlStrb_t strb,
  output logic      respValid
);
  ctrlState_t state, nextState;
  logic       wayQ;

  always_comb begin
    strb      = '0;
    nextState = state;
    reqReady  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strb.latchReq = 1'b1;
          nextState     = ST_PROBE;
        end
      end
      ST_PROBE: begin
        strb.recordLookup = 1'b1;
        nextState         = ST_RESP;
        if (stat.isWrite) begin
          if (stat.hit)          strb.markDirty = 1'b1;
          else if (stat.baiFits) strb.placeBai  = 1'b1;
          else if (stat.tsiFits) strb.placeTsi  = 1'b1;
          else                   nextState      = ST_EVICT;
        end
      end
      ST_EVICT: begin
        strb.wbEmit = 1'b1;
        strb.wbWay  = wayQ;
        if (wayQ) nextState = ST_PLACE;
      end
      ST_PLACE: begin
        strb.clearTsi = 1'b1;
        strb.placeTsi = 1'b1;
        nextState     = ST_RESP;
      end
      ST_RESP: begin
        strb.respOut = 1'b1;
        nextState    = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign respValid = strb.respOut;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      wayQ  <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_EVICT) wayQ <= ~wayQ;
      else                   wayQ <= 1'b0;
    end
  end
endmodule

// File: rtl/dual_index_ccache.sv
module dual_index_ccache
  import dixc_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int INDEX_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic               reqWrite,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [6:0]         reqSize,
  input  logic               reqDirty,
  output logic               respValid,
  output logic               respHit,
  output logic [INDEX_W-1:0] respSet,
  output logic [1:0]         respCount,
  output logic               wbValid,
  output logic [ADDR_W-1:0]  wbAddr
);
  ctrlStrb_t strb;
  dpStat_t   stat;

  dixc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .stat(stat), .strb(strb), .respValid(respValid)
  );

  dixc_datapath #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .stat(stat),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqDirty(reqDirty), .reqWrite(reqWrite),
    .respHit(respHit), .respSet(respSet), .respCount(respCount),
    .wbValid(wbValid), .wbAddr(wbAddr)
  );
endmodule

// File: rtl/dixc_checker.sv
module dixc_checker #(
  parameter int ADDR_W  = 12,
  parameter int INDEX_W = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic               reqReady,
  input logic               respValid,
  input logic               respHit,
  input logic [1:0]         respCount,
  input logic               wbValid,
  input logic [ADDR_W-1:0]  wbAddr
);
  assert_resp_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid);

  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  assert_resp_not_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !reqReady);

  assert_wb_inside_request_R6: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (!reqReady && !respValid));

  assert_wb_single_line_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && $past(wbValid)) |-> (wbAddr != $past(wbAddr)));

  assert_count_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> (respCount <= 2'd2));

  assert_hit_has_lines_R3: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respHit) |-> (respCount != 2'd0));
endmodule

bind dual_index_ccache dixc_checker #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .respValid(respValid), .respHit(respHit), .respCount(respCount),
  .wbValid(wbValid), .wbAddr(wbAddr)
);

// File: tb/dual_index_ccache_tb.sv
module dual_index_ccache_tb_top;
  localparam int ADDR_W  = 12;
  localparam int INDEX_W = 4;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               reqValid = 1'b0;
  logic               reqReady;
  logic               reqWrite = 1'b0;
  logic [ADDR_W-1:0]  reqAddr = '0;
  logic [6:0]         reqSize = '0;
  logic               reqDirty = 1'b0;
  logic               respValid, respHit, wbValid;
  logic [INDEX_W-1:0] respSet;
  logic [1:0]         respCount;
  logic [ADDR_W-1:0]  wbAddr;

  int checks = 0;
  int failures = 0;
  int wbN = 0;
  logic [ADDR_W-1:0] wbLog [8];
  logic gotHit;
  logic [INDEX_W-1:0] gotSet;
  logic [1:0] gotCount;

  always #2 clk = ~clk;

  dual_index_ccache #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqSize(reqSize), .reqDirty(reqDirty),
    .respValid(respValid), .respHit(respHit), .respSet(respSet), .respCount(respCount),
    .wbValid(wbValid), .wbAddr(wbAddr)
  );

  always @(negedge clk) begin
    if (rstN && wbValid) begin
      if (wbN < 8) wbLog[wbN] = wbAddr;
      wbN = wbN + 1;
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReq(input logic wr, input int addr, input int size, input logic dirty);
    int guard = 0;
    wbN = 0;
    @(negedge clk);
    reqValid = 1'b1;
    reqWrite = wr;
    reqAddr  = addr[ADDR_W-1:0];
    reqSize  = size[6:0];
    reqDirty = dirty;
    @(negedge clk);
    reqValid = 1'b0;
    while (!respValid && guard < 50) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 50) check(1'b0, "R8 response timeout", 0, 1);
    gotHit   = respHit;
    gotSet   = respSet;
    gotCount = respCount;
    @(negedge clk);
    check(!respValid, "R8 single response pulse", int'(respValid), 0);
  endtask

  task automatic expectResp(input string req, input logic hit, input int setIdx, input int cnt);
    check(gotHit == hit, {req, " hit"}, int'(gotHit), int'(hit));
    check(gotSet == setIdx[INDEX_W-1:0], {req, " set"}, int'(gotSet), setIdx);
    check(gotCount == cnt[1:0], {req, " count"}, int'(gotCount), cnt);
  endtask

  task automatic testReset();
    check(reqReady == 1'b1, "R1 ready after reset", int'(reqReady), 1);
    check(respValid == 1'b0, "R1 no response after reset", int'(respValid), 0);
    check(wbValid == 1'b0, "R1 no writeback after reset", int'(wbValid), 0);
    doReq(1'b0, 'h005, 0, 1'b0);
    expectResp("R1 R3 read miss on empty cache", 1'b0, 5, 0);
  endtask

  task automatic testPairSharesSet();
    // 0x012/0x013: conventional sets 2/3, bandwidth-aware set {001,1}=3 (R2, R4)
    doReq(1'b1, 'h012, 20, 1'b0);
    expectResp("R4 R9 first compressed line", 1'b0, 3, 1);
    doReq(1'b1, 'h013, 20, 1'b0);
    expectResp("R4 R9 neighbour line joins", 1'b0, 3, 2);
    doReq(1'b0, 'h012, 0, 1'b0);
    expectResp("R3 read returns both lines", 1'b1, 3, 2);
    // 0x020/0x021: bit4=0 so both map to set 0; 0x021 leaves its conventional set 1 (R2)
    doReq(1'b1, 'h020, 16, 1'b0);
    expectResp("R2 even line set", 1'b0, 0, 1);
    doReq(1'b1, 'h021, 16, 1'b0);
    expectResp("R2 odd line shares set", 1'b0, 0, 2);
    doReq(1'b0, 'h021, 0, 1'b0);
    expectResp("R2 R3 odd line found in rotated set", 1'b1, 0, 2);
  endtask

  task automatic testFallback();
    // 0x032: bandwidth-aware set 3 has no free way, goes to conventional set 2 (R5)
    doReq(1'b1, 'h032, 10, 1'b0);
    expectResp("R5 full rotated set falls back", 1'b0, 2, 1);
    // 0x045 incompressible: conventional set 5 even though rotated set 4 is empty (R5)
    doReq(1'b1, 'h045, 50, 1'b1);
    expectResp("R5 incompressible to conventional set", 1'b0, 5, 1);
    check(wbN == 0, "R6 no writeback into empty set", wbN, 0);
  endtask

  task automatic testEvictSingle();
    doReq(1'b1, 'h085, 40, 1'b0);
    expectResp("R6 new line after eviction", 1'b0, 5, 1);
    check(wbN == 1, "R6 one dirty writeback", wbN, 1);
    check(wbLog[0] == 12'h045, "R6 writeback address", int'(wbLog[0]), 'h045);
    doReq(1'b1, 'h0C5, 40, 1'b0);
    check(wbN == 0, "R6 clean line dropped silently", wbN, 0);
    expectResp("R6 R9 replacement placed", 1'b0, 5, 1);
    doReq(1'b0, 'h045, 0, 1'b0);
    expectResp("R6 evicted line misses", 1'b0, 5, 0);
    doReq(1'b0, 'h0C5, 0, 1'b0);
    expectResp("R3 incompressible line hit", 1'b1, 5, 1);
  endtask

  task automatic testEvictPair();
    // 0x016 -> rotated set 7; 0x017 -> set 7 (both indices); 0x037 maps to 7 under both (R6)
    doReq(1'b1, 'h016, 30, 1'b1);
    expectResp("R4 dirty line to rotated set", 1'b0, 7, 1);
    doReq(1'b1, 'h017, 30, 1'b1);
    expectResp("R4 second dirty line", 1'b0, 7, 2);
    doReq(1'b1, 'h037, 20, 1'b0);
    check(wbN == 2, "R6 two dirty writebacks", wbN, 2);
    check(wbLog[0] == 12'h016, "R6 way0 written back first", int'(wbLog[0]), 'h016);
    check(wbLog[1] == 12'h017, "R6 way1 written back second", int'(wbLog[1]), 'h017);
    expectResp("R6 R9 set holds only new line", 1'b0, 7, 1);
  endtask

  task automatic testFillHit();
    doReq(1'b1, 'h012, 20, 1'b1);
    expectResp("R7 fill of present line", 1'b1, 3, 2);
    check(wbN == 0, "R7 fill hit causes no writeback", wbN, 0);
    // 0x053 incompressible, conventional set 3 full: only 0x012 is now dirty (R7, R6)
    doReq(1'b1, 'h053, 60, 1'b0);
    check(wbN == 1, "R7 dirty bit taken from fill hit", wbN, 1);
    check(wbLog[0] == 12'h012, "R7 dirtied line written back", int'(wbLog[0]), 'h012);
    expectResp("R6 incompressible after eviction", 1'b0, 3, 1);
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPairSharesSet();
    testFallback();
    testEvictSingle();
    testEvictPair();
    testFillHit();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule